// File: doc/BRIEF.md
# Cache Event Counter Bank

This block is the performance monitor for one cache cluster. Software reaches it through two registers only: a select register that holds an internal 12-bit address, and a data register that reads or writes whatever that address names. Behind that port sit eight 32-bit event counters and one 64-bit cycle counter. Three 32-bit mask registers hold the per-counter state: counter enable, interrupt enable and overflow. Each mask is changed only through a pair of addresses, one that sets bits and one that clears them.

Events are picked from a matrix of 8 groups by 256 codes. A 64-bit resource register holds one 8-bit code for each group, and each event counter holds the number of the group it follows. The counter then adds one in every cycle that the strobe for its group's chosen code is high. Any overflow flag whose interrupt enable is also set drives a level interrupt. The interrupt stays high until software clears the flag.

Top module: `cache_evt_monitor`

## Requirements
- R1: A write on the select port latches a 12-bit address. Data reads return the selected register at once, zero-extended to 64 bits, and data writes act on it. Any address outside the map reads as zero and ignores writes. The per-counter window for counter i (0..7) is 0x420+0x10*i plus offset 0 (count control), 1 (value), 3 (filter) or 4 (group type). Addresses 0x4A0 and above hold no counters.
- R2: The control register sits at 0x400. Bit 0 is the global count enable and reads back. Bits [15:11] read the number of event counters, which is 8, so a reset value reads as 0x4000. A write with bit 1 set zeroes every event counter, and a write with bit 2 set zeroes the cycle counter. Writing 0x6 therefore zeroes all counters.
- R3: There are three masks: counter enable (clear 0x403, set 0x404), interrupt enable (clear 0x405, set 0x406) and overflow (clear 0x407, set 0x408). A write to a set address sets the bits written as one, and a write to a clear address clears them. All other bits keep their value. Both addresses of a pair read the current mask. Only bits 0..7 (event counters) and bit 31 (cycle counter) exist, and every other bit reads zero.
- R4: Event counter i adds one at each clock edge where the strobe at index 256*g+code is high. Here g is its group type (bits [2:0] of its type register) and code is resource bits [8g+7:8g]. The counter enable bit i, control bit 0 and resource bit 63 must all be set. No other strobe changes the counter.
- R5: The resource register at 0x410 is 64 bits wide. Its bit 63 is both the matrix enable and the top code bit of group 7, so with the matrix enabled, group 7 can only select codes 0x80..0xFF.
- R6: The cycle counter (value at 0x40A, 64 bits) adds one at every clock edge while control bit 0 and mask bit 31 are both set.
- R7: Writing a counter's value address preloads the counter with the written data, truncated to 32 bits for event counters. A preload wins over an increment at the same edge.
- R8: A counter that steps from all ones to zero sets its overflow bit: bit i for event counter i, bit 31 for the cycle counter. The counter keeps counting from zero.
- R9: The interrupt output is high while any overflow bit has its interrupt-enable bit set. It stays high until that flag or its enable is cleared.
- R10: Count control (0x409 and per counter) and filter registers store and return 32 bits. Type registers store and return 3 bits.
- R11: After reset, all registers and counters are zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Load the select register |
| sel_wdata | input | 12 | Internal register address |
| dat_wr | input | 1 | Write the selected register |
| dat_wdata | input | 64 | Write data |
| dat_rdata | output | 64 | Read data of the selected register |
| evt_strobe | input | 2048 | Single-cycle event strobes, index 256*group+code |
| irq | output | 1 | Level interrupt on enabled overflow |

## Verification
A select write takes effect at the next clock edge, and the read data for the new address is valid right after that edge. The bench therefore drives every input at the falling edge and samples the read data at the next falling edge. Data writes, counter increments and preloads all act at the edge that samples them, so the bench counts edges between enabling and disabling counting and expects exactly that many increments. For example, a cycle counter enabled across twelve edges must have gained twelve. An overflow flag and the interrupt change at the edge where the counter wraps, so both are checked at the falling edge after the last strobe. Counts are read only after counting has been switched off, so they are stable when sampled.

// File: rtl/cem_pkg.sv
package cem_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 64;
    localparam int EVT_W   = 32;
    localparam int CYC_W   = 64;
    localparam int MASK_W  = 32;
    localparam int CYC_BIT = 31;
    localparam int GROUPS  = 8;
    localparam int CODE_W  = 8;
    localparam int CODES   = 1 << CODE_W;
    localparam int GRP_W   = $clog2(GROUPS);
    localparam int IDX_W   = 5;
    localparam int NUM_LSB = 11;
    localparam int NUM_W   = 5;
    localparam int MTX_EN_BIT = 63;

    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h400;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 12'h403;
    localparam logic [ADDR_W-1:0] A_EN_SET = 12'h404;
    localparam logic [ADDR_W-1:0] A_IE_CLR = 12'h405;
    localparam logic [ADDR_W-1:0] A_IE_SET = 12'h406;
    localparam logic [ADDR_W-1:0] A_OV_CLR = 12'h407;
    localparam logic [ADDR_W-1:0] A_OV_SET = 12'h408;
    localparam logic [ADDR_W-1:0] A_CCTL   = 12'h409;
    localparam logic [ADDR_W-1:0] A_CVAL   = 12'h40A;
    localparam logic [ADDR_W-1:0] A_RSEL   = 12'h410;

    localparam int unsigned PC_BASE   = 32'h420;
    localparam int unsigned PC_STRIDE = 16;
    localparam logic [3:0] OFS_CTL = 4'h0;
    localparam logic [3:0] OFS_VAL = 4'h1;
    localparam logic [3:0] OFS_FLT = 4'h3;
    localparam logic [3:0] OFS_TYP = 4'h4;

    typedef enum logic [3:0] {
        ACC_NONE, ACC_CTRL, ACC_EN_CLR, ACC_EN_SET, ACC_IE_CLR, ACC_IE_SET,
        ACC_OV_CLR, ACC_OV_SET, ACC_CCTL, ACC_CVAL, ACC_RSEL,
        ACC_PC_CTL, ACC_PC_VAL, ACC_PC_FLT, ACC_PC_TYP
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [IDX_W-1:0]  idx;
    } acc_t;

    // Bits that exist in every mask: one per event counter plus the cycle bit.
    function automatic logic [MASK_W-1:0] impl_mask(input int unsigned n);
        logic [MASK_W-1:0] m;
        m = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [MASK_W-1:0] mask_next(
        input logic [MASK_W-1:0] cur,
        input logic              do_set,
        input logic              do_clr,
        input logic [MASK_W-1:0] bits
    );
        logic [MASK_W-1:0] r;
        r = cur;
        if (do_set) r = r | bits;
        if (do_clr) r = r & ~bits;
        return r;
    endfunction

    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a, input int unsigned n);
        acc_t        r;
        int unsigned ai;
        r.kind = ACC_NONE;
        r.idx  = '0;
        ai     = 32'(a);
        if (ai >= PC_BASE && ai < PC_BASE + PC_STRIDE * n) begin
            r.idx = IDX_W'((ai - PC_BASE) / PC_STRIDE);
            case (a[3:0])
                OFS_CTL: r.kind = ACC_PC_CTL;
                OFS_VAL: r.kind = ACC_PC_VAL;
                OFS_FLT: r.kind = ACC_PC_FLT;
                OFS_TYP: r.kind = ACC_PC_TYP;
                default: r.kind = ACC_NONE;
            endcase
        end else begin
            case (a)
                A_CTRL:   r.kind = ACC_CTRL;
                A_EN_CLR: r.kind = ACC_EN_CLR;
                A_EN_SET: r.kind = ACC_EN_SET;
                A_IE_CLR: r.kind = ACC_IE_CLR;
                A_IE_SET: r.kind = ACC_IE_SET;
                A_OV_CLR: r.kind = ACC_OV_CLR;
                A_OV_SET: r.kind = ACC_OV_SET;
                A_CCTL:   r.kind = ACC_CCTL;
                A_CVAL:   r.kind = ACC_CVAL;
                A_RSEL:   r.kind = ACC_RSEL;
                default:  r.kind = ACC_NONE;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/cem_counter.sv
module cem_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         wrap
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (clr)  q <= '0;
        else if (ld)   q <= ld_val;
        else if (inc)  q <= q + W'(1);
    end

    // Wrap only when the increment actually lands.
    assign wrap = inc && !clr && !ld && (&q);
endmodule

// File: rtl/cem_evsel.sv
module cem_evsel
    import cem_pkg::*;
#(
    parameter int N_CTR = 8
) (
    input  logic [GROUPS*CODES-1:0]         strobes,
    input  logic [DATA_W-1:0]               rsel,
    input  logic [N_CTR-1:0][GRP_W-1:0]     types,
    input  logic [N_CTR-1:0]                gate,
    output logic [N_CTR-1:0]                hit
);
    logic [GROUPS-1:0] grp_hit;
    logic              mtx_en;

    assign mtx_en = rsel[MTX_EN_BIT];

    // One code mux per group, shared by every counter bound to that group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [CODES-1:0]  slice;
        logic [CODE_W-1:0] code;
        assign slice      = strobes[g*CODES +: CODES];
        assign code       = rsel[g*CODE_W +: CODE_W];
        assign grp_hit[g] = slice[code];
    end

    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
        assign hit[i] = gate[i] && mtx_en && grp_hit[types[i]];
    end
endmodule

// File: rtl/cem_regs.sv
module cem_regs
    import cem_pkg::*;
#(
    parameter int N_CTR = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sel_wr,
    input  logic [ADDR_W-1:0]             sel_wdata,
    input  logic                          dat_wr,
    input  logic [DATA_W-1:0]             dat_wdata,
    output logic [DATA_W-1:0]             dat_rdata,
    input  logic [N_CTR-1:0][EVT_W-1:0]   ev_vals,
    input  logic [CYC_W-1:0]              cyc_val,
    input  logic [N_CTR-1:0]              ev_wrap,
    input  logic                          cyc_wrap,
    output logic                          gen_en,
    output logic [MASK_W-1:0]             cnten_q,
    output logic [MASK_W-1:0]             inten_q,
    output logic [MASK_W-1:0]             ovf_q,
    output logic [DATA_W-1:0]             rsel_q,
    output logic [N_CTR-1:0][GRP_W-1:0]   types_q,
    output logic [N_CTR-1:0]              ev_ld,
    output logic                          cyc_ld,
    output logic                          ev_clr,
    output logic                          cyc_clr,
    output acc_t                          cur_acc
);
    localparam logic [MASK_W-1:0] IMPL = impl_mask(N_CTR);

    logic [ADDR_W-1:0]             sel_q;
    logic [EVT_W-1:0]              cyc_ctl_q;
    logic [N_CTR-1:0][EVT_W-1:0]   pc_ctl_q;
    logic [N_CTR-1:0][EVT_W-1:0]   pc_flt_q;
    logic [MASK_W-1:0]             wd32;
    logic [MASK_W-1:0]             wrap_vec;
    logic [MASK_W-1:0]             en_n, ie_n, ov_n;
    acc_kind_e                     wk;

    assign cur_acc = decode_addr(sel_q, N_CTR);
    assign wd32    = dat_wdata[MASK_W-1:0];
    assign wk      = dat_wr ? cur_acc.kind : ACC_NONE;

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= '0;
        else if (sel_wr) sel_q <= sel_wdata;
    end

    // Mask registers: set/clear pairs, hardware wraps always set overflow.
    always_comb begin
        wrap_vec              = '0;
        wrap_vec[N_CTR-1:0]   = ev_wrap;
        wrap_vec[CYC_BIT]     = cyc_wrap;
        en_n = mask_next(cnten_q, wk == ACC_EN_SET, wk == ACC_EN_CLR, wd32);
        ie_n = mask_next(inten_q, wk == ACC_IE_SET, wk == ACC_IE_CLR, wd32);
        ov_n = mask_next(ovf_q,   wk == ACC_OV_SET, wk == ACC_OV_CLR, wd32) | wrap_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnten_q <= '0;
            inten_q <= '0;
            ovf_q   <= '0;
        end else begin
            cnten_q <= en_n & IMPL;
            inten_q <= ie_n & IMPL;
            ovf_q   <= ov_n & IMPL;
        end
    end

    // Plain configuration storage.
    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en    <= 1'b0;
            rsel_q    <= '0;
            cyc_ctl_q <= '0;
            pc_ctl_q  <= '0;
            pc_flt_q  <= '0;
            types_q   <= '0;
        end else begin
            case (wk)
                ACC_CTRL: gen_en    <= dat_wdata[0];
                ACC_CCTL: cyc_ctl_q <= wd32;
                ACC_RSEL: rsel_q    <= dat_wdata;
                default: ;
            endcase
            for (int i = 0; i < N_CTR; i++) begin
                if (cur_acc.idx == IDX_W'(i)) begin
                    if (wk == ACC_PC_CTL) pc_ctl_q[i] <= wd32;
                    if (wk == ACC_PC_FLT) pc_flt_q[i] <= wd32;
                    if (wk == ACC_PC_TYP) types_q[i]  <= dat_wdata[GRP_W-1:0];
                end
            end
        end
    end

    for (genvar i = 0; i < N_CTR; i++) begin : g_ld
        assign ev_ld[i] = (wk == ACC_PC_VAL) && (cur_acc.idx == IDX_W'(i));
    end
    assign cyc_ld  = (wk == ACC_CVAL);
    assign ev_clr  = (wk == ACC_CTRL) && dat_wdata[1];
    assign cyc_clr = (wk == ACC_CTRL) && dat_wdata[2];

    // Read path: combinational from the latched select.
    always_comb begin
        dat_rdata = '0;
        case (cur_acc.kind)
            ACC_CTRL: begin
                dat_rdata[0] = gen_en;
                dat_rdata[NUM_LSB +: NUM_W] = NUM_W'(N_CTR);
            end
            ACC_EN_CLR, ACC_EN_SET: dat_rdata[MASK_W-1:0] = cnten_q;
            ACC_IE_CLR, ACC_IE_SET: dat_rdata[MASK_W-1:0] = inten_q;
            ACC_OV_CLR, ACC_OV_SET: dat_rdata[MASK_W-1:0] = ovf_q;
            ACC_CCTL: dat_rdata[EVT_W-1:0] = cyc_ctl_q;
            ACC_CVAL: dat_rdata = cyc_val;
            ACC_RSEL: dat_rdata = rsel_q;
            default: begin
                for (int i = 0; i < N_CTR; i++) begin
                    if (cur_acc.idx == IDX_W'(i)) begin
                        case (cur_acc.kind)
                            ACC_PC_CTL: dat_rdata[EVT_W-1:0] = pc_ctl_q[i];
                            ACC_PC_VAL: dat_rdata[EVT_W-1:0] = ev_vals[i];
                            ACC_PC_FLT: dat_rdata[EVT_W-1:0] = pc_flt_q[i];
                            ACC_PC_TYP: dat_rdata[GRP_W-1:0] = types_q[i];
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/cache_evt_monitor.sv
module cache_evt_monitor
    import cem_pkg::*;
#(
    parameter int N_CTR = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel_wr,
    input  logic [ADDR_W-1:0]         sel_wdata,
    input  logic                      dat_wr,
    input  logic [DATA_W-1:0]         dat_wdata,
    output logic [DATA_W-1:0]         dat_rdata,
    input  logic [GROUPS*CODES-1:0]   evt_strobe,
    output logic                      irq
);
    logic [N_CTR-1:0][EVT_W-1:0]  ev_vals;
    logic [CYC_W-1:0]             cyc_val;
    logic [N_CTR-1:0]             ev_wrap, ev_ld, ev_hit;
    logic                         cyc_wrap, cyc_ld, ev_clr, cyc_clr, cyc_inc;
    logic                         gen_en;
    logic [MASK_W-1:0]            cnten_q, inten_q, ovf_q;
    logic [DATA_W-1:0]            rsel_q;
    logic [N_CTR-1:0][GRP_W-1:0]  types_q;
    logic [N_CTR-1:0]             ev_gate;
    acc_t                         cur_acc;

    cem_regs #(.N_CTR(N_CTR)) regs_i (
        .clk(clk), .rst(rst),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .ev_vals(ev_vals), .cyc_val(cyc_val),
        .ev_wrap(ev_wrap), .cyc_wrap(cyc_wrap),
        .gen_en(gen_en), .cnten_q(cnten_q), .inten_q(inten_q), .ovf_q(ovf_q),
        .rsel_q(rsel_q), .types_q(types_q),
        .ev_ld(ev_ld), .cyc_ld(cyc_ld), .ev_clr(ev_clr), .cyc_clr(cyc_clr),
        .cur_acc(cur_acc)
    );

    assign ev_gate = cnten_q[N_CTR-1:0] & {N_CTR{gen_en}};

    cem_evsel #(.N_CTR(N_CTR)) evsel_i (
        .strobes(evt_strobe), .rsel(rsel_q), .types(types_q),
        .gate(ev_gate), .hit(ev_hit)
    );

    for (genvar i = 0; i < N_CTR; i++) begin : g_evc
        cem_counter #(.W(EVT_W)) cnt_i (
            .clk(clk), .rst(rst), .clr(ev_clr), .ld(ev_ld[i]),
            .ld_val(dat_wdata[EVT_W-1:0]), .inc(ev_hit[i]),
            .q(ev_vals[i]), .wrap(ev_wrap[i])
        );
    end

    assign cyc_inc = gen_en && cnten_q[CYC_BIT];

    cem_counter #(.W(CYC_W)) cyc_i (
        .clk(clk), .rst(rst), .clr(cyc_clr), .ld(cyc_ld),
        .ld_val(dat_wdata[CYC_W-1:0]), .inc(cyc_inc),
        .q(cyc_val), .wrap(cyc_wrap)
    );

    assign irq = |(ovf_q & inten_q);
endmodule

// File: rtl/cache_evt_monitor_chk.sv
module cache_evt_monitor_chk
    import cem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              dat_wr,
    input logic [DATA_W-1:0] dat_wdata,
    input acc_t              cur_acc,
    input logic [MASK_W-1:0] ovf_q,
    input logic [EVT_W-1:0]  ev0_val,
    input logic              ev0_inc,
    input logic              ev0_ld,
    input logic              ev0_wrap,
    input logic              ev_clr,
    input logic [CYC_W-1:0]  cyc_val,
    input logic              cyc_inc,
    input logic              cyc_ld,
    input logic              cyc_clr,
    input logic              cyc_wrap
);
    logic clr_path;
    assign clr_path = dat_wr && (cur_acc.kind == ACC_OV_CLR || cur_acc.kind == ACC_IE_CLR);

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        irq && !clr_path |=> irq);                                                  // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_q != '0));                                                     // R9
    AST_EV_STEP: assert property (@(posedge clk) disable iff (rst)
        ev0_inc && !ev0_ld && !ev_clr |=> ev0_val == $past(ev0_val) + EVT_W'(1));   // R4
    AST_EV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ev0_inc && !ev0_ld && !ev_clr |=> $stable(ev0_val));                       // R4
    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        cyc_inc && !cyc_ld && !cyc_clr |=> cyc_val == $past(cyc_val) + CYC_W'(1));  // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ev0_ld && !ev_clr |=> ev0_val == $past(dat_wdata[EVT_W-1:0]));              // R7
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        ev_clr |=> ev0_val == '0);                                                  // R2
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        ev0_wrap |=> ovf_q[0]);                                                     // R8
    AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        cyc_wrap |=> ovf_q[CYC_BIT]);                                               // R8
endmodule

bind cache_evt_monitor cache_evt_monitor_chk chk_i (
    .clk(clk), .rst(rst), .irq(irq), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .cur_acc(cur_acc), .ovf_q(ovf_q),
    .ev0_val(ev_vals[0]), .ev0_inc(ev_hit[0]), .ev0_ld(ev_ld[0]), .ev0_wrap(ev_wrap[0]),
    .ev_clr(ev_clr), .cyc_val(cyc_val), .cyc_inc(cyc_inc), .cyc_ld(cyc_ld),
    .cyc_clr(cyc_clr), .cyc_wrap(cyc_wrap)
);

// File: tb/cache_evt_monitor_tb_top.sv
`timescale 1ns/1ps
module cache_evt_monitor_tb_top;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_wr = 1'b0;
    logic [11:0]   sel_wdata = '0;
    logic          dat_wr = 1'b0;
    logic [63:0]   dat_wdata = '0;
    logic [63:0]   dat_rdata;
    logic [2047:0] evt_strobe = '0;
    logic          irq;
    int            checks = 0;
    int            errors = 0;
    logic [63:0]   rd;

    always #4 clk = ~clk;

    cache_evt_monitor dut_i (
        .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .evt_strobe(evt_strobe), .irq(irq)
    );

    // {counter[3:0], group[3:0], code[7:0], pulses[7:0]}
    localparam logic [23:0] VEC [0:4] = '{
        {4'd0, 4'd0, 8'h01, 8'd3},
        {4'd3, 4'd2, 8'h42, 8'd5},
        {4'd7, 4'd5, 8'hA7, 8'd1},
        {4'd1, 4'd7, 8'h85, 8'd4},
        {4'd5, 4'd3, 8'h00, 8'd6}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic reg_write(input logic [11:0] a, input logic [63:0] d);
        sel_wr = 1'b1; sel_wdata = a;
        @(negedge clk);
        sel_wr = 1'b0; dat_wr = 1'b1; dat_wdata = d;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [63:0] d);
        sel_wr = 1'b1; sel_wdata = a;
        @(negedge clk);
        sel_wr = 1'b0;
        d = dat_rdata;
    endtask

    task automatic pulse(input int idx);
        evt_strobe[idx] = 1'b1;
        @(negedge clk);
        evt_strobe[idx] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R11 act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state, R2 counter count field
        check("R11 irq after reset", {63'd0, irq}, 64'd0);
        reg_read(12'h400, rd); check("R2 control reset readback", rd, 64'h4000);
        reg_read(12'h408, rd); check("R11 overflow reset", rd, 64'd0);
        reg_read(12'h40A, rd); check("R11 cycle counter reset", rd, 64'd0);

        // R6 cycle counter: 12 enabled edges
        reg_write(12'h40A, 64'd5);
        reg_write(12'h404, 64'h8000_0000);
        reg_write(12'h400, 64'd1);
        repeat (10) @(negedge clk);
        reg_write(12'h400, 64'd0);
        reg_read(12'h40A, rd); check("R6 cycle count", rd, 64'd17);

        // R8 cycle wrap: wraps at first enabled edge, steps once more
        reg_write(12'h40A, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_write(12'h400, 64'd1);
        reg_write(12'h400, 64'd0);
        reg_read(12'h408, rd); check("R8 cycle overflow flag", rd, 64'h8000_0000);
        reg_read(12'h40A, rd); check("R8 cycle after wrap", rd, 64'd1);
        reg_write(12'h407, 64'hFFFF_FFFF);
        reg_read(12'h408, rd); check("R3 overflow cleared", rd, 64'd0);
        reg_write(12'h403, 64'hFFFF_FFFF);

        // R3 set/clear pairs and implemented bits
        reg_write(12'h404, 64'hFFFF_FFFF);
        reg_read(12'h404, rd); check("R3 enable set implemented bits", rd, 64'h8000_00FF);
        reg_write(12'h403, 64'h0000_000F);
        reg_read(12'h403, rd); check("R3 enable clear partial", rd, 64'h8000_00F0);
        reg_write(12'h403, 64'hFFFF_FFFF);

        // R4/R5 event matrix table
        for (int v = 0; v < 5; v++) begin
            automatic int ctr = int'(VEC[v][23:20]);
            automatic int grp = int'(VEC[v][19:16]);
            automatic logic [7:0] code = VEC[v][15:8];
            automatic int np = int'(VEC[v][7:0]);
            automatic logic [63:0] rs = (64'(code) << (8*grp)) | 64'h8000_0000_0000_0000;
            automatic int og = (grp + 1) % 8;
            reg_write(12'h400, 64'd0);
            reg_write(12'h410, rs);
            reg_write(12'(12'h424 + 16*ctr), 64'(grp));
            reg_write(12'h404, 64'(1) << ctr);
            reg_write(12'h400, 64'd7);
            for (int p = 0; p < np; p++) pulse(grp*256 + int'(code));
            pulse(grp*256 + int'(code ^ 8'h80));
            pulse(grp*256 + int'(code ^ 8'h80));
            pulse(og*256);
            reg_write(12'h400, 64'd0);
            reg_read(12'(12'h421 + 16*ctr), rd);
            check($sformatf("R4 R5 table entry %0d count", v), rd, 64'(np));
        end

        // R2 reset-all clears counters
        reg_write(12'h400, 64'h6);
        reg_read(12'h471, rd); check("R2 event counter cleared", rd, 64'd0);
        reg_read(12'h40A, rd); check("R2 cycle counter cleared", rd, 64'd0);

        // R4 matrix enable off: no count
        reg_write(12'h410, 64'h11);
        reg_write(12'h424, 64'd0);
        reg_write(12'h404, 64'd1);
        reg_write(12'h400, 64'd7);
        pulse(16'h11); pulse(16'h11); pulse(16'h11);
        reg_write(12'h400, 64'd0);
        reg_read(12'h421, rd); check("R4 matrix disabled no count", rd, 64'd0);

        // R8/R9 event overflow and interrupt
        reg_write(12'h410, 64'h8000_0000_0000_0011);
        reg_write(12'h421, 64'hFFFF_FFFE);
        reg_write(12'h406, 64'd1);
        reg_write(12'h407, 64'hFFFF_FFFF);
        reg_write(12'h400, 64'd1);
        pulse(16'h11);
        check("R9 irq low before wrap", {63'd0, irq}, 64'd0);
        pulse(16'h11);
        check("R9 irq on wrap", {63'd0, irq}, 64'd1);
        reg_write(12'h400, 64'd0);
        reg_read(12'h408, rd); check("R8 event overflow flag", rd, 64'd1);
        reg_read(12'h407, rd); check("R3 clear address reads flags", rd, 64'd1);
        reg_read(12'h421, rd); check("R8 counter wrapped to zero", rd, 64'd0);
        repeat (5) @(negedge clk);
        check("R9 irq held", {63'd0, irq}, 64'd1);
        reg_write(12'h407, 64'd1);
        check("R9 irq cleared", {63'd0, irq}, 64'd0);

        // R7 preload wins over a same-edge increment
        reg_write(12'h400, 64'd1);
        evt_strobe[16'h11] = 1'b1;
        reg_write(12'h421, 64'd100);
        evt_strobe[16'h11] = 1'b0;
        reg_read(12'h421, rd); check("R7 preload wins", rd, 64'd100);
        reg_write(12'h400, 64'd0);

        // R10 storage
        reg_write(12'h440, 64'hDEAD_BEEF);
        reg_read(12'h440, rd); check("R10 count control store", rd, 64'hDEAD_BEEF);
        reg_write(12'h493, 64'h000E_0007);
        reg_read(12'h493, rd); check("R10 filter store", rd, 64'h000E_0007);
        reg_write(12'h444, 64'hFF);
        reg_read(12'h444, rd); check("R10 type keeps 3 bits", rd, 64'h7);
        reg_write(12'h409, 64'h1234_5678);
        reg_read(12'h409, rd); check("R10 cycle control store", rd, 64'h1234_5678);

        // R1 full-width resource readback and unmapped addresses
        reg_write(12'h410, 64'h0123_4567_89AB_CDEF);
        reg_read(12'h410, rd); check("R1 resource 64-bit readback", rd, 64'h0123_4567_89AB_CDEF);
        reg_write(12'h401, 64'hFFFF);
        reg_read(12'h401, rd); check("R1 unmapped reads zero", rd, 64'd0);
        reg_write(12'h4A1, 64'h55);
        reg_read(12'h4A1, rd); check("R1 beyond counters reads zero", rd, 64'd0);
        reg_read(12'h400, rd); check("R1 unmapped write no effect", rd, 64'h4000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule